// File: doc/BRIEF.md
# Byte-Addressed Interrupt Status Controller

This block gathers twelve interrupt sources into one sticky pending word, filters that word through a mask and drives one active-high interrupt line. Software reaches it through a byte-wide register port. A serial-slave front end, which is not part of this block, feeds that port with transaction starts, written bytes and read requests. The pending and mask words are 16 bits wide and each is split into a low byte and a high byte. A pair of write-one-to-clear acknowledge bytes clears pending bits.

The port uses an auto-incrementing register pointer. In a write transaction the first byte sets the pointer. Each later byte is written to the register the pointer selects, and then the pointer advances. Each read request returns the selected register and also advances the pointer, so one transaction can cover several adjacent registers. The six mapped registers sit at consecutive addresses from a base address, and this adjacency is what makes burst access work.

Top module: `irq_status_ctrl`

## Requirements
- R1: `irq` is high exactly when some status bit is 1 while the matching mask bit is 0.
- R2: After reset the mask reads 0x0FFF, which masks all twelve sources. The status reads zero and `irq` is low.
- R3: A write to acknowledge-low (0x14) or acknowledge-high (0x15) clears every status bit of that byte where the written value holds a 1. Both acknowledge addresses read as 0x00.
- R4: A write to mask-low (0x10) replaces mask bits 7:0 and leaves bits 15:8 unchanged. A write to mask-high (0x11) replaces bits 15:8 and leaves bits 7:0 unchanged.
- R5: Status bits 7:0 follow `gen_evt[7:0]`. Bit 8 is the periodic tick, bit 9 the alarm match, bit 10 the update error and bit 11 the power button. Bits 15:12 always read 0. Status-low is at 0x12 and status-high at 0x13.
- R6: The power-button bit is set only on a low-to-high change of `pwr_btn`. While the button is held, an acknowledge keeps the bit cleared.
- R7: The first byte written after `xfer_start` loads the pointer. Each later written byte goes to the pointed register, and then the pointer increments.
- R8: A read request places the pointed register on `rd_data` one cycle later and increments the pointer. Unmapped addresses read 0x00 and ignore writes. Writes to the status registers have no effect.
- R9: Status bits are sticky. When a source event and an acknowledge of the same bit land in the same cycle, the bit ends up set.
- R10: `irq` is registered. It changes one clock after the status or mask change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xfer_start | input | 1 | One-cycle pulse: a write transaction starts |
| wr_valid | input | 1 | One-cycle pulse: `wr_data` holds a written byte |
| wr_data | input | 8 | Written byte (pointer or register data) |
| rd_req | input | 1 | One-cycle pulse: read the pointed register |
| rd_data | output | 8 | Read byte, valid the cycle after `rd_req` |
| gen_evt | input | 8 | General event pulses for status bits 7:0 |
| tick_evt | input | 1 | Periodic tick event pulse |
| alarm_evt | input | 1 | Alarm match event pulse |
| upd_err_evt | input | 1 | Time update error event pulse |
| pwr_btn | input | 1 | Power-button level |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case to reach from the ports is an event and an acknowledge of the same bit in one clock. The acknowledge has to be the data byte of a write transaction whose pointer already selects acknowledge-high. The bench sets the pointer first, then raises the tick pulse in the same cycle as the acknowledge data byte, and afterwards reads the status back. A second hard case is holding the power button across an acknowledge. The bench keeps the level high, clears the bit, waits several cycles, reads it back as zero, and then releases and presses the button again to show that a new rising edge still sets it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register selected by the current pointer value
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_STAT_LO,
    SEL_STAT_HI,
    SEL_ACK_LO,
    SEL_ACK_HI
  } reg_sel_e;

  // Named sources occupy the top of the source vector
  localparam int NUM_NAMED_SRC = 4;
  // Number of mapped registers starting at the base address
  localparam int NUM_MAPPED = 6;

  function automatic reg_sel_e decode_offset(input int unsigned off);
    reg_sel_e sel;
    case (off)
      0:       sel = SEL_MASK_LO;
      1:       sel = SEL_MASK_HI;
      2:       sel = SEL_STAT_LO;
      3:       sel = SEL_STAT_HI;
      4:       sel = SEL_ACK_LO;
      5:       sel = SEL_ACK_HI;
      default: sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_ptr_ctrl.sv
module irq_ptr_ctrl
  import irq_agg_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter logic [DATA_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output reg_sel_e          sel_o
);

  logic              first_q, first_d;
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic [DATA_W-1:0] offset;

  // Next-state: start arms the pointer load, writes take priority over reads
  always_comb begin
    first_d  = first_q;
    ptr_d    = ptr_q;
    reg_wr_o = 1'b0;
    reg_rd_o = 1'b0;
    if (xfer_start) begin
      first_d = 1'b1;
    end else if (wr_valid) begin
      if (first_q) begin
        ptr_d   = wr_data;
        first_d = 1'b0;
      end else begin
        reg_wr_o = 1'b1;
        ptr_d    = ptr_q + 1'b1;
      end
    end else if (rd_req) begin
      reg_rd_o = 1'b1;
      ptr_d    = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      ptr_q   <= '0;
    end else begin
      first_q <= first_d;
      ptr_q   <= ptr_d;
    end
  end

  assign offset = ptr_q - BASE_ADDR;

  always_comb begin
    sel_o = decode_offset(int'(unsigned'(offset)));
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int STAT_W   = 16,
  parameter int NUM_SRC  = 12,
  parameter int EDGE_IDX = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [STAT_W-1:0]  clr_i,
  output logic [STAT_W-1:0]  stat_o
);

  localparam int PAD_W = STAT_W - NUM_SRC;

  logic [NUM_SRC-1:0] set_src;
  logic [STAT_W-1:0]  set_vec;
  logic [STAT_W-1:0]  stat_q, stat_d;

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g == EDGE_IDX) begin : g_edge
        logic lvl_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            lvl_q <= 1'b0;
          end else begin
            lvl_q <= src_i[g];
          end
        end
        assign set_src[g] = src_i[g] & ~lvl_q;
      end else begin : g_pulse
        assign set_src[g] = src_i[g];
      end
    end
  endgenerate

  generate
    if (PAD_W > 0) begin : g_pad
      assign set_vec = {{PAD_W{1'b0}}, set_src};
    end else begin : g_nopad
      assign set_vec = set_src;
    end
  endgenerate

  // Set beats clear so an event arriving with its acknowledge is kept
  always_comb begin
    stat_d = (stat_q & ~clr_i) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int                  DATA_W  = 8,
  parameter int                  MASK_W  = 16,
  parameter logic [MASK_W-1:0]   RST_VAL = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] data_i,
  output logic [MASK_W-1:0] mask_o
);

  logic [MASK_W-1:0] mask_q, mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = wr_lo | wr_hi;
    mask_d  = mask_q;
    if (wr_lo) begin
      mask_d[DATA_W-1:0] = data_i;
    end
    if (wr_hi) begin
      mask_d[MASK_W-1:DATA_W] = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= RST_VAL;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic              irq_o
);

  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(stat_i & ~mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_agg_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                NUM_SRC   = 12,
  parameter logic [DATA_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                xfer_start,
  input  logic                                wr_valid,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                rd_req,
  output logic [DATA_W-1:0]                   rd_data,
  input  logic [NUM_SRC-NUM_NAMED_SRC-1:0]    gen_evt,
  input  logic                                tick_evt,
  input  logic                                alarm_evt,
  input  logic                                upd_err_evt,
  input  logic                                pwr_btn,
  output logic                                irq
);

  localparam int                STAT_W   = 2 * DATA_W;
  localparam int                BTN_IDX  = NUM_SRC - 1;
  localparam logic [STAT_W-1:0] MASK_RST = STAT_W'((1 << NUM_SRC) - 1);

  logic               rst_sync_n;
  logic               reg_wr;
  logic               reg_rd;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] src_vec;
  logic [STAT_W-1:0]  clr_vec;
  logic [STAT_W-1:0]  stat;
  logic [STAT_W-1:0]  mask;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rd_q, rd_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_ptr_ctrl #(.DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .xfer_start (xfer_start),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .reg_wr_o   (reg_wr),
    .reg_rd_o   (reg_rd),
    .sel_o      (sel)
  );

  // Source order fixes the status bit positions
  assign src_vec = {pwr_btn, upd_err_evt, alarm_evt, tick_evt, gen_evt};

  // Write-one-to-clear vector from the acknowledge bytes
  always_comb begin
    clr_vec = '0;
    if (reg_wr && (sel == SEL_ACK_LO)) begin
      clr_vec[DATA_W-1:0] = wr_data;
    end
    if (reg_wr && (sel == SEL_ACK_HI)) begin
      clr_vec[STAT_W-1:DATA_W] = wr_data;
    end
  end

  irq_status_bank #(.STAT_W(STAT_W), .NUM_SRC(NUM_SRC), .EDGE_IDX(BTN_IDX)) u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_i  (src_vec),
    .clr_i  (clr_vec),
    .stat_o (stat)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .MASK_W(STAT_W), .RST_VAL(MASK_RST)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_lo  (reg_wr && (sel == SEL_MASK_LO)),
    .wr_hi  (reg_wr && (sel == SEL_MASK_HI)),
    .data_i (wr_data),
    .mask_o (mask)
  );

  irq_out_reg #(.STAT_W(STAT_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_i (stat),
    .mask_i (mask),
    .irq_o  (irq)
  );

  // Read multiplexer: acknowledge and unmapped addresses return zero
  always_comb begin
    case (sel)
      SEL_MASK_LO: rd_mux = mask[DATA_W-1:0];
      SEL_MASK_HI: rd_mux = mask[STAT_W-1:DATA_W];
      SEL_STAT_LO: rd_mux = stat[DATA_W-1:0];
      SEL_STAT_HI: rd_mux = stat[STAT_W-1:DATA_W];
      default:     rd_mux = '0;
    endcase
  end

  always_comb begin
    rd_d = rd_q;
    if (reg_rd) begin
      rd_d = rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 16,
  parameter int NUM_SRC = 12,
  parameter int BTN_IDX = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] ptr,
  input logic              pwr_btn,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] mask,
  input logic [STAT_W-1:0] clr,
  input logic [STAT_W-1:0] set,
  input logic              irq
);

  // R1 R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(stat) & ~$past(mask))));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((stat & $past(clr & ~set)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((stat & $past(set)) == $past(set)));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat >> NUM_SRC) == '0));

  // R6
  btn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_btn && $past(pwr_btn) && clr[BTN_IDX]) |=> !stat[BTN_IDX]);

  // R7
  ptr_wr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (ptr == $past(ptr) + 1'b1));

  // R8
  ptr_rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> (ptr == $past(ptr) + 1'b1));

endmodule

bind irq_status_ctrl irq_agg_chk #(
  .DATA_W  (DATA_W),
  .STAT_W  (STAT_W),
  .NUM_SRC (NUM_SRC),
  .BTN_IDX (BTN_IDX)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .reg_wr  (reg_wr),
  .reg_rd  (reg_rd),
  .ptr     (u_ptr.ptr_q),
  .pwr_btn (pwr_btn),
  .stat    (stat),
  .mask    (mask),
  .clr     (clr_vec),
  .set     (u_stat.set_vec),
  .irq     (irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

  localparam logic [7:0] A_MASK_LO = 8'h10;
  localparam logic [7:0] A_MASK_HI = 8'h11;
  localparam logic [7:0] A_STAT_LO = 8'h12;
  localparam logic [7:0] A_STAT_HI = 8'h13;
  localparam logic [7:0] A_ACK_LO  = 8'h14;
  localparam logic [7:0] A_ACK_HI  = 8'h15;
  localparam logic [7:0] A_UNMAP   = 8'h30;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       xfer_start, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic [7:0] gen_evt;
  logic       tick_evt, alarm_evt, upd_err_evt, pwr_btn;
  logic [7:0] rd_data;
  logic       irq;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_start  (xfer_start),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .rd_req      (rd_req),
    .rd_data     (rd_data),
    .gen_evt     (gen_evt),
    .tick_evt    (tick_evt),
    .alarm_evt   (alarm_evt),
    .upd_err_evt (upd_err_evt),
    .pwr_btn     (pwr_btn),
    .irq         (irq)
  );

  // Monitor: the read byte is valid after the edge that took rd_req
  always @(posedge clk) rd_seen <= rd_req;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      if (exp_q.size() == 0) begin
        errors++;
        checks++;
        $display("FAIL R8: unexpected read data act=%02h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: read act=%02h exp=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_wr(input logic [7:0] addr);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    wr_valid   = 1'b1;
    wr_data    = addr;
    @(negedge clk);
    wr_valid   = 1'b0;
  endtask

  task automatic put(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq act=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xfer_start = 1'b0; wr_valid = 1'b0; rd_req = 1'b0;
    wr_data = '0; gen_evt = '0; tick_evt = 1'b0; alarm_evt = 1'b0;
    upd_err_evt = 1'b0; pwr_btn = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);

    // R2: reset values, burst read across all six registers (R8 increment)
    chk_irq(1'b0, "R2");
    begin_wr(A_MASK_LO);
    rd(8'hFF, "R2 mask lo");
    rd(8'h0F, "R2 mask hi");
    rd(8'h00, "R2 stat lo");
    rd(8'h00, "R8 stat hi");
    rd(8'h00, "R3 ack lo read");
    rd(8'h00, "R3 ack hi read");

    // R5: tick sets bit 8, masked so no interrupt (R1)
    tick_evt = 1'b1; step(1); tick_evt = 1'b0;
    step(1);
    chk_irq(1'b0, "R1 masked");
    begin_wr(A_STAT_HI);
    rd(8'h01, "R5 tick bit8");

    // R4 / R10: unmask high byte, irq follows one cycle later
    begin_wr(A_MASK_HI);
    put(8'h00);
    chk_irq(1'b0, "R10 latency");
    step(1);
    chk_irq(1'b1, "R1 unmasked");
    begin_wr(A_MASK_LO);
    rd(8'hFF, "R4 low kept");
    rd(8'h00, "R4 high written");

    // R3: acknowledge clears
    begin_wr(A_ACK_HI);
    put(8'h01);
    step(1);
    chk_irq(1'b0, "R3 ack irq");

    // R5: alarm and update error together, partial acknowledge
    alarm_evt = 1'b1; upd_err_evt = 1'b1; step(1);
    alarm_evt = 1'b0; upd_err_evt = 1'b0;
    begin_wr(A_STAT_HI);
    rd(8'h06, "R5 alarm+err");
    chk_irq(1'b1, "R1 alarm");
    begin_wr(A_ACK_HI);
    put(8'h02);
    begin_wr(A_STAT_HI);
    rd(8'h04, "R3 partial ack");
    begin_wr(A_ACK_HI);
    put(8'h04);
    step(1);
    chk_irq(1'b0, "R3 all acked");

    // R6: button rising edge, held button not re-set
    pwr_btn = 1'b1; step(2);
    begin_wr(A_STAT_HI);
    rd(8'h08, "R6 button edge");
    begin_wr(A_ACK_HI);
    put(8'h08);
    step(5);
    begin_wr(A_STAT_HI);
    rd(8'h00, "R6 held no reset");
    chk_irq(1'b0, "R6 irq held");
    pwr_btn = 1'b0; step(2);
    pwr_btn = 1'b1; step(2);
    begin_wr(A_STAT_HI);
    rd(8'h08, "R6 second edge");
    begin_wr(A_ACK_HI);
    put(8'h08);
    pwr_btn = 1'b0;

    // R5 general source with low mask
    gen_evt = 8'h08; step(1); gen_evt = 8'h00;
    begin_wr(A_STAT_LO);
    rd(8'h08, "R5 gen bit3");
    chk_irq(1'b0, "R1 low masked");
    begin_wr(A_MASK_LO);
    put(8'hF7);
    step(1);
    chk_irq(1'b1, "R4 low unmask");
    begin_wr(A_ACK_LO);
    put(8'h08);
    step(1);
    chk_irq(1'b0, "R3 ack lo");

    // R9: tick and acknowledge of bit 8 in the same cycle
    begin_wr(A_ACK_HI);
    tick_evt = 1'b1;
    put(8'h01);
    tick_evt = 1'b0;
    begin_wr(A_STAT_HI);
    rd(8'h01, "R9 set wins");
    step(1);
    chk_irq(1'b1, "R9 irq");
    begin_wr(A_ACK_HI);
    put(8'h01);

    // R8: unmapped address and read-only status ignore writes
    begin_wr(A_UNMAP);
    put(8'h55);
    begin_wr(A_UNMAP);
    rd(8'h00, "R8 unmapped");
    begin_wr(A_STAT_LO);
    put(8'hFF);
    begin_wr(A_STAT_LO);
    rd(8'h00, "R8 status ro");

    // R7: burst write with pointer increment
    begin_wr(A_MASK_LO);
    put(8'hAA);
    put(8'h55);
    begin_wr(A_MASK_LO);
    rd(8'hAA, "R7 burst lo");
    rd(8'h55, "R7 burst hi");
    gen_evt = 8'h01; step(1); gen_evt = 8'h00;
    step(1);
    chk_irq(1'b1, "R1 bit0 unmasked");

    step(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8: pending reads act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule